// File: doc/BRIEF.md
# Convolutional Symbol Interleaver and De-interleaver

This block holds both halves of a byte-wide convolutional (multi-branch delay-line) interleaver used on a streaming forward-error-correction link. On the sending side a commutator steps one branch per valid symbol around 12 branches. Each branch is a delay line whose length grows in steps of 17 symbols, so a burst of channel errors is spread across many codewords. On the receiving side the same commutator drives branches with the complementary lengths. After both halves every symbol has waited the same number of symbol slots, and the original order comes back.

The two halves have independent valid/data ports, so they can sit at the two ends of a channel. A symbol moves only when its valid is high. While valid is low the commutator and every delay line hold still, so idle cycles change neither the order nor the contents. A synchronous reset clears all branch storage and returns both commutators to branch 0. The receiving side raises a flag once enough symbols have passed to flush the zeros left in storage by reset.

Top module: `conv_ilv_pair`

## Requirements
- R1: While `rst` is high and in the cycle after, `ilv_out_valid`, `dil_out_valid` and `dil_primed` are 0, and both output data buses are 0.
- R2: `ilv_out_valid` is `ilv_in_valid` delayed by one clock, and `dil_out_valid` is `dil_in_valid` delayed by one clock.
- R3: Count valid symbols on the sending side from 0 after reset. Output symbol n equals input symbol n − 204·(n mod 12), or 0 when that index is negative.
- R4: Count valid symbols on the receiving side from 0 after reset. Output symbol n equals receiving-side input symbol n − 204·(11 − (n mod 12)), or 0 when that index is negative. Branch 11 is therefore a pass-through.
- R5: With the sending output fed straight into the receiving input, receiving output symbol p equals original input symbol p − 2244 for every p ≥ 2244.
- R6: Idle cycles (valid low) between symbols do not change any output symbol value. Each output data bus holds its last value while its output valid is low.
- R7: `dil_primed` is high exactly from the receiving output symbol with index 2244 onward, and it stays high until reset.
- R8: A sending-side symbol whose index is a multiple of 12 leaves on `ilv_out_data` in the very next clock cycle, unchanged.
- R9: A reset in mid-stream discards all symbols stored before it. Afterwards R3 holds again with indices restarting at 0, so stored positions read back as 0 and not as older data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ilv_in_valid | input | 1 | Sending-side symbol strobe |
| ilv_in_data | input | 8 | Sending-side symbol |
| ilv_out_valid | output | 1 | Interleaved symbol strobe |
| ilv_out_data | output | 8 | Interleaved symbol |
| dil_in_valid | input | 1 | Receiving-side symbol strobe |
| dil_in_data | input | 8 | Receiving-side symbol |
| dil_out_valid | output | 1 | Restored symbol strobe |
| dil_out_data | output | 8 | Restored symbol |
| dil_primed | output | 1 | High once restored symbols no longer carry reset residue |

## Verification
A commutator that skips, repeats or wraps at the wrong count sends symbols to the wrong branch. This shows up at once: within the first 12 symbols, the pass-through branch outputs stop matching their inputs. A wrong pointer or length in one delay line stays hidden while that branch still reads out zeros after reset. It appears only when the first stored symbol returns, up to 204·11 symbols later. This is why the streams run past 2244 symbols and every output index is compared with the formula. A faulty stall path only shows in runs with gaps, so one run inserts idle cycles and checks that the results match the continuous run.

// File: rtl/cil_pkg.sv
package cil_pkg;

    typedef enum logic {
        DIR_SPREAD  = 1'b0,
        DIR_RESTORE = 1'b1
    } cil_dir_e;

    // Length of branch j: rising lengths when spreading, falling when restoring
    function automatic int branch_len(input int j, input int n_br, input int unit,
                                      input cil_dir_e dir);
        return (dir == DIR_RESTORE) ? (n_br - 1 - j) * unit : j * unit;
    endfunction

endpackage

// File: rtl/cil_delay_line.sv
module cil_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0]           ptr;
        logic [DEPTH-1:0][W-1:0] mem;
    } line_t;

    line_t line_d, line_q;

    // Circular buffer: the slot read this visit is refilled with the new symbol
    always_comb begin
        line_d = line_q;
        if (en) begin
            line_d.mem[line_q.ptr] = din;
            line_d.ptr = (line_q.ptr == PW'(DEPTH - 1)) ? '0 : line_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end

    assign dout = line_q.mem[line_q.ptr];

endmodule

// File: rtl/cil_branch_bank.sv
module cil_branch_bank
    import cil_pkg::*;
#(
    parameter int       W    = 8,
    parameter int       NBR  = 12,
    parameter int       UNIT = 17,
    parameter cil_dir_e DIR  = DIR_SPREAD
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int SW = (NBR > 1) ? $clog2(NBR) : 1;

    typedef struct packed {
        logic [SW-1:0] sel;
        logic          vld;
        logic [W-1:0]  dat;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NBR-1:0][W-1:0] br_out;

    for (genvar j = 0; j < NBR; j++) begin : g_br
        localparam int LEN = branch_len(j, NBR, UNIT, DIR);
        if (LEN == 0) begin : g_wire
            assign br_out[j] = in_data;
        end else begin : g_line
            logic en_j;
            assign en_j = in_valid && (bank_q.sel == SW'(j));
            cil_delay_line #(.W(W), .DEPTH(LEN)) u_line (
                .clk  (clk),
                .rst  (rst),
                .en   (en_j),
                .din  (in_data),
                .dout (br_out[j])
            );
        end
    end

    always_comb begin
        bank_d     = bank_q;
        bank_d.vld = in_valid;
        if (in_valid) begin
            bank_d.dat = br_out[bank_q.sel];
            bank_d.sel = (bank_q.sel == SW'(NBR - 1)) ? '0 : bank_q.sel + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    assign out_valid = bank_q.vld;
    assign out_data  = bank_q.dat;

endmodule

// File: rtl/cil_prime_count.sv
module cil_prime_count #(
    parameter int LIMIT = 2244
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic primed
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          primed;
    } prime_t;

    prime_t pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (in_valid) begin
            if (pc_q.cnt == CW'(LIMIT)) pc_d.primed = 1'b1;
            else                        pc_d.cnt    = pc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign primed = pc_q.primed;

endmodule

// File: rtl/conv_ilv_pair.sv
module conv_ilv_pair
    import cil_pkg::*;
#(
    parameter int SYM_W    = 8,
    parameter int BRANCHES = 12,
    parameter int UNIT     = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ilv_in_valid,
    input  logic [SYM_W-1:0] ilv_in_data,
    output logic             ilv_out_valid,
    output logic [SYM_W-1:0] ilv_out_data,
    input  logic             dil_in_valid,
    input  logic [SYM_W-1:0] dil_in_data,
    output logic             dil_out_valid,
    output logic [SYM_W-1:0] dil_out_data,
    output logic             dil_primed
);
    localparam int LAT = BRANCHES * (BRANCHES - 1) * UNIT;

    cil_branch_bank #(.W(SYM_W), .NBR(BRANCHES), .UNIT(UNIT), .DIR(DIR_SPREAD)) u_spread (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (ilv_in_valid),
        .in_data   (ilv_in_data),
        .out_valid (ilv_out_valid),
        .out_data  (ilv_out_data)
    );

    cil_branch_bank #(.W(SYM_W), .NBR(BRANCHES), .UNIT(UNIT), .DIR(DIR_RESTORE)) u_restore (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (dil_in_valid),
        .in_data   (dil_in_data),
        .out_valid (dil_out_valid),
        .out_data  (dil_out_data)
    );

    cil_prime_count #(.LIMIT(LAT)) u_prime (
        .clk      (clk),
        .rst      (rst),
        .in_valid (dil_in_valid),
        .primed   (dil_primed)
    );

endmodule

// File: rtl/conv_ilv_pair_chk.sv
module conv_ilv_pair_chk #(
    parameter int SYM_W    = 8,
    parameter int BRANCHES = 12,
    parameter int UNIT     = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             ilv_in_valid,
    input logic [SYM_W-1:0] ilv_in_data,
    input logic             ilv_out_valid,
    input logic [SYM_W-1:0] ilv_out_data,
    input logic             dil_in_valid,
    input logic [SYM_W-1:0] dil_in_data,
    input logic             dil_out_valid,
    input logic [SYM_W-1:0] dil_out_data,
    input logic             dil_primed
);
    localparam int LAT = BRANCHES * (BRANCHES - 1) * UNIT;
    localparam int SW  = (BRANCHES > 1) ? $clog2(BRANCHES) : 1;
    localparam int KW  = $clog2(LAT + 2);

    logic [SW-1:0] tx_br, rx_br;
    logic [KW-1:0] rx_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_br   <= '0;
            rx_br   <= '0;
            rx_seen <= '0;
        end else begin
            if (ilv_in_valid) tx_br <= (tx_br == SW'(BRANCHES - 1)) ? '0 : tx_br + 1'b1;
            if (dil_in_valid) rx_br <= (rx_br == SW'(BRANCHES - 1)) ? '0 : rx_br + 1'b1;
            if (dil_in_valid && rx_seen != KW'(LAT + 1)) rx_seen <= rx_seen + 1'b1;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!ilv_out_valid && !dil_out_valid && !dil_primed
                 && ilv_out_data == '0 && dil_out_data == '0));

    p_tx_valid_r2: assert property (@(posedge clk) disable iff (rst)
        ilv_in_valid |=> ilv_out_valid);
    p_tx_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !ilv_in_valid |=> !ilv_out_valid);
    p_rx_valid_r2: assert property (@(posedge clk) disable iff (rst)
        dil_in_valid |=> dil_out_valid);
    p_rx_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !dil_in_valid |=> !dil_out_valid);

    p_rx_last_branch_r4: assert property (@(posedge clk) disable iff (rst)
        (dil_in_valid && rx_br == SW'(BRANCHES - 1)) |=> dil_out_data == $past(dil_in_data));

    p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !ilv_in_valid |=> $stable(ilv_out_data));
    p_rx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !dil_in_valid |=> $stable(dil_out_data));

    p_primed_r7: assert property (@(posedge clk) disable iff (rst)
        dil_primed == (rx_seen == KW'(LAT + 1)));
    p_primed_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        dil_primed |=> dil_primed);

    p_branch0_r8: assert property (@(posedge clk) disable iff (rst)
        (ilv_in_valid && tx_br == '0) |=> ilv_out_data == $past(ilv_in_data));

endmodule

bind conv_ilv_pair conv_ilv_pair_chk #(
    .SYM_W    (SYM_W),
    .BRANCHES (BRANCHES),
    .UNIT     (UNIT)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ilv_in_valid  (ilv_in_valid),
    .ilv_in_data   (ilv_in_data),
    .ilv_out_valid (ilv_out_valid),
    .ilv_out_data  (ilv_out_data),
    .dil_in_valid  (dil_in_valid),
    .dil_in_data   (dil_in_data),
    .dil_out_valid (dil_out_valid),
    .dil_out_data  (dil_out_data),
    .dil_primed    (dil_primed)
);

// File: tb/conv_ilv_pair_tb.sv
`timescale 1ns/1ps
module conv_ilv_pair_tb;
    localparam int NB   = 12;
    localparam int U    = 17;
    localparam int SPAN = NB * U;
    localparam int TOT  = NB * (NB - 1) * U;
    localparam int LOGN = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ilv_in_valid = 1'b0;
    logic [7:0] ilv_in_data  = '0;
    logic       ilv_out_valid, dil_out_valid, dil_primed;
    logic [7:0] ilv_out_data, dil_out_data;
    logic       dil_in_valid;
    logic [7:0] dil_in_data;

    always #2 clk = ~clk;

    // Channel: sending output straight into receiving input
    assign dil_in_valid = ilv_out_valid;
    assign dil_in_data  = ilv_out_data;

    conv_ilv_pair u_dut (
        .clk           (clk),
        .rst           (rst),
        .ilv_in_valid  (ilv_in_valid),
        .ilv_in_data   (ilv_in_data),
        .ilv_out_valid (ilv_out_valid),
        .ilv_out_data  (ilv_out_data),
        .dil_in_valid  (dil_in_valid),
        .dil_in_data   (dil_in_data),
        .dil_out_valid (dil_out_valid),
        .dil_out_data  (dil_out_data),
        .dil_primed    (dil_primed)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [7:0] in_log  [LOGN];
    logic [7:0] ilv_log [LOGN];
    logic [7:0] dil_log [LOGN];
    bit         pr_log  [LOGN];
    int n_in, n_ilv, n_dil, r2_err, r6_err;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int base);
        return 8'(((i * 37 + base) % 255) + 1);
    endfunction

    task automatic clear_logs();
        n_in = 0; n_ilv = 0; n_dil = 0; r2_err = 0; r6_err = 0;
    endtask

    // Starts and ends just after a falling edge
    task automatic cyc(input bit v, input logic [7:0] d);
        logic [7:0] prev;
        prev = ilv_out_data;
        ilv_in_valid = v;
        ilv_in_data  = d;
        if (v && n_in < LOGN) begin in_log[n_in] = d; n_in++; end
        @(posedge clk);
        @(negedge clk);
        if (ilv_out_valid !== v) r2_err++;
        if (!v && ilv_out_data !== prev) r6_err++;
        if (ilv_out_valid && n_ilv < LOGN) begin ilv_log[n_ilv] = ilv_out_data; n_ilv++; end
        if (dil_out_valid && n_dil < LOGN) begin
            dil_log[n_dil] = dil_out_data; pr_log[n_dil] = dil_primed; n_dil++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ilv_in_valid = 1'b0; ilv_in_data = '0;
        repeat (2) @(negedge clk);
        chk(ilv_out_valid === 1'b0, "R1 ilv_out_valid", int'(ilv_out_valid), 0);
        chk(dil_out_valid === 1'b0, "R1 dil_out_valid", int'(dil_out_valid), 0);
        chk(dil_primed    === 1'b0, "R1 dil_primed", int'(dil_primed), 0);
        chk(ilv_out_data === 8'h00 && dil_out_data === 8'h00, "R1 data zero",
            int'(ilv_out_data) + int'(dil_out_data), 0);
        rst = 1'b0;
        clear_logs();
    endtask

    task automatic run_stream(input int n, input int gap_every, input int base);
        for (int i = 0; i < n; i++) begin
            if (gap_every != 0 && (i % gap_every) == gap_every - 1) cyc(1'b0, 8'hA5);
            cyc(1'b1, pat(i, base));
        end
        cyc(1'b0, 8'h00);
        cyc(1'b0, 8'h00);
    endtask

    // Sending side vs formula (R3); the branch-0 subset is checked as R8
    task automatic check_spread(input string tag, input bit only_b0);
        int bad = 0, a = 0, e = 0;
        for (int k = 0; k < n_ilv; k++) begin
            int src;
            logic [7:0] ex;
            if (only_b0 && (k % NB) != 0) continue;
            src = k - SPAN * (k % NB);
            ex  = (src >= 0) ? in_log[src] : 8'h00;
            if (ilv_log[k] !== ex) begin
                if (bad == 0) begin a = int'(ilv_log[k]); e = int'(ex); end
                bad++;
            end
        end
        chk(bad == 0, tag, a, e);
    endtask

    task automatic check_stream(input string sfx);
        int bad4 = 0, bad5 = 0, bad7 = 0, a4 = 0, e4 = 0, a5 = 0, e5 = 0, a7 = 0, e7 = 0;
        chk(n_ilv == n_in && r2_err == 0, {"R2 ilv valid follow ", sfx}, n_ilv + r2_err, n_in);
        check_spread({"R3 spread order ", sfx}, 1'b0);
        check_spread({"R8 branch0 pass ", sfx}, 1'b1);
        for (int k = 0; k < n_dil; k++) begin
            int src;
            logic [7:0] ex;
            src = k - SPAN * (NB - 1 - (k % NB));
            ex  = (src >= 0) ? ilv_log[src] : 8'h00;
            if (dil_log[k] !== ex) begin
                if (bad4 == 0) begin a4 = int'(dil_log[k]); e4 = int'(ex); end
                bad4++;
            end
            if (k >= TOT && dil_log[k] !== in_log[k - TOT]) begin
                if (bad5 == 0) begin a5 = int'(dil_log[k]); e5 = int'(in_log[k - TOT]); end
                bad5++;
            end
            if (pr_log[k] != (k >= TOT)) begin
                if (bad7 == 0) begin a7 = int'(pr_log[k]); e7 = int'(k >= TOT); end
                bad7++;
            end
        end
        chk(n_dil == n_in, {"R2 dil valid follow ", sfx}, n_dil, n_in);
        chk(bad4 == 0, {"R4 restore order ", sfx}, a4, e4);
        chk(bad5 == 0, {"R5 end-to-end ", sfx}, a5, e5);
        chk(bad7 == 0, {"R7 primed flag ", sfx}, a7, e7);
    endtask

    task automatic t_reset();
        do_reset();
    endtask

    task automatic t_continuous();
        do_reset();
        run_stream(2600, 0, 11);
        check_stream("continuous");
    endtask

    task automatic t_gappy();
        do_reset();
        run_stream(2600, 3, 11);
        chk(r6_err == 0, "R6 output held while idle", r6_err, 0);
        check_stream("with gaps R6");
    endtask

    task automatic t_midreset();
        do_reset();
        run_stream(400, 0, 5);
        do_reset();
        run_stream(400, 0, 90);
        check_spread("R9 storage cleared by reset", 1'b0);
        chk(n_ilv == n_in, "R9 commutator restart count", n_ilv, n_in);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        clear_logs();
        t_reset();
        t_continuous();
        t_gappy();
        t_midreset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule